// File: doc/BRIEF.md
# Byte-Lane Parity Check and Generate

This block handles byte parity on a 36-bit data port. The word is split into four 9-bit lanes: bits [8:0], [17:9], [26:18] and [35:27]. In each lane the top bit carries parity and the lower eight bits carry data. A single select input chooses odd or even parity, and that choice applies to checking and to generation alike.

On the incoming side, the block checks each lane that the current bus size actually uses. If any of those lanes fails, it drives an active-low error flag. On the outgoing side, it handles a read with generation enabled by replacing the top bit of every lane with freshly computed parity. The data bits are left untouched.

One set of parity trees is shared between input checking and mailbox parity generation. While a mailbox read with generation is set up, the trees are borrowed for that purpose and the error flag is held inactive. The whole block is combinational and holds no state.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k occupies bits [9k+8:9k] for k = 0..3, and bit 9k+8 is that lane's parity bit; a parity fault in any one lane alone is detected.
- R2: With `odd_sel` = 1 a lane passes when its nine bits hold an odd number of ones; with `odd_sel` = 0 it passes when they hold an even number.
- R3: Outside the mailbox-generation case, `perr_n` is 0 when at least one checked lane fails and 1 when every checked lane passes.
- R4: Bus-size code `bus_size` selects the checked lanes: 2'b00 (long word) all four lanes, 2'b10 (word) lanes 0 and 1, 2'b01 (byte) lane 0 only, 2'b11 (mailbox) all four lanes. Faults in unchecked lanes leave `perr_n` at 1.
- R5: When `is_write` = 0 and `gen_en` = 1, `tx_word` equals `rd_word` except that each lane's bit 9k+8 is replaced by parity computed from that lane's eight data bits per `odd_sel`.
- R6: When `gen_en` = 0 or `is_write` = 1, `tx_word` equals `rd_word` bit for bit.
- R7: When `is_write` = 0, `bus_size` = 2'b11 and `gen_en` = 1, `perr_n` is 1 whatever `rx_word` holds.
- R8: `perr_n` and `tx_word` follow their inputs combinationally, with no clock edge and no latching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even, for check and generate |
| gen_en | input | 1 | Enables parity generation on reads |
| is_write | input | 1 | 1 for a write cycle on the port, 0 for a read |
| bus_size | input | 2 | Bus-size code; 2'b11 means mailbox access |
| rx_word | input | 36 | Word presented on the port for checking |
| rd_word | input | 36 | Word to be driven out on a read |
| tx_word | output | 36 | Read word, with parity bits replaced when generating |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
The assertions evaluate combinational relations, so they assume every input carries a known 0 or 1 and that the outputs are read only after the logic has settled. Under those assumptions they tie the flag and the read word to parity reductions over whole 9-bit lanes. The bench drives only fully known values. It changes inputs half a clock period before it samples, so the assertions and checks never look at a half-updated set of inputs. The one exception is the combinational test, which deliberately changes inputs between clock edges and then waits a short fixed delay before sampling.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
  parameter int unsigned LANE_W = 9;
  parameter int unsigned LANES  = 4;
  parameter int unsigned DATA_W = LANE_W - 1;
  parameter int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    BUS_LONG = 2'b00,
    BUS_BYTE = 2'b01,
    BUS_WORD = 2'b10,
    BUS_MBOX = 2'b11
  } bus_size_e;
endpackage

// File: rtl/lane_parity_tree.sv
// One parity tree per lane: yields the parity bit that makes the lane
// satisfy the selected sense (odd when odd_sel is high).
module lane_parity_tree #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic [LANES*DATA_W-1:0] data_in,
  input  logic                    odd_sel,
  output logic [LANES-1:0]        par_out
);
  for (genvar l = 0; l < LANES; l++) begin : g_tree
    assign par_out[l] = (^data_in[l*DATA_W +: DATA_W]) ^ odd_sel;
  end
endmodule

// File: rtl/lane_mask_dec.sv
// Bus-size code to the set of lanes that are checked.
module lane_mask_dec
  import lane_parity_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [1:0]       bus_size,
  output logic [LANES-1:0] lane_mask
);
  localparam int unsigned HALF = (LANES >= 2) ? LANES / 2 : 1;

  bus_size_e   size_q;
  int unsigned used;

  assign size_q = bus_size_e'(bus_size);

  always_comb begin
    unique case (size_q)
      BUS_BYTE: used = 1;
      BUS_WORD: used = HALF;
      default:  used = LANES;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l] = (l < used);
  end
endmodule

// File: rtl/lane_parity_out.sv
// Read-path assembly: substitutes parity bits per lane when generating.
module lane_parity_out #(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic [LANES*LANE_W-1:0] rd_word,
  input  logic [LANES-1:0]        gen_par,
  input  logic                    gen_on,
  output logic [LANES*LANE_W-1:0] tx_word
);
  localparam int unsigned DATA_W = LANE_W - 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign tx_word[l*LANE_W +: DATA_W] = rd_word[l*LANE_W +: DATA_W];
    assign tx_word[l*LANE_W + DATA_W]  = gen_on ? gen_par[l]
                                                : rd_word[l*LANE_W + DATA_W];
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lane_parity_pkg::*;
(
  input  logic              odd_sel,
  input  logic              gen_en,
  input  logic              is_write,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] tx_word,
  output logic              perr_n
);
  localparam int unsigned PACK_W = LANES * DATA_W;

  logic [PACK_W-1:0] rx_data;
  logic [PACK_W-1:0] rd_data;
  logic [PACK_W-1:0] shared_in;
  logic [LANES-1:0]  rx_par;
  logic [LANES-1:0]  shared_par;
  logic [LANES-1:0]  fifo_par;
  logic [LANES-1:0]  gen_par;
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  lane_bad;
  logic              gen_on;
  logic              tree_borrowed;

  // Split each lane into its data byte and its parity bit.
  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign rx_data[l*DATA_W +: DATA_W] = rx_word[l*LANE_W +: DATA_W];
    assign rd_data[l*DATA_W +: DATA_W] = rd_word[l*LANE_W +: DATA_W];
    assign rx_par[l]                   = rx_word[l*LANE_W + DATA_W];
  end

  assign gen_on        = !is_write && gen_en;
  assign tree_borrowed = gen_on && (bus_size_e'(bus_size) == BUS_MBOX);

  // The checking trees are taken over for mailbox parity generation.
  assign shared_in = tree_borrowed ? rd_data : rx_data;

  lane_parity_tree #(.DATA_W(DATA_W), .LANES(LANES)) u_shared_tree (
    .data_in (shared_in),
    .odd_sel (odd_sel),
    .par_out (shared_par)
  );

  lane_parity_tree #(.DATA_W(DATA_W), .LANES(LANES)) u_fifo_tree (
    .data_in (rd_data),
    .odd_sel (odd_sel),
    .par_out (fifo_par)
  );

  lane_mask_dec #(.LANES(LANES)) u_mask (
    .bus_size  (bus_size),
    .lane_mask (lane_mask)
  );

  assign gen_par  = tree_borrowed ? shared_par : fifo_par;
  assign lane_bad = (rx_par ^ shared_par) & lane_mask;
  assign perr_n   = tree_borrowed || !(|lane_bad);

  lane_parity_out #(.LANE_W(LANE_W), .LANES(LANES)) u_out (
    .rd_word (rd_word),
    .gen_par (gen_par),
    .gen_on  (gen_on),
    .tx_word (tx_word)
  );
endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk
  import lane_parity_pkg::*;
(
  input logic              odd_sel,
  input logic              gen_en,
  input logic              is_write,
  input logic [1:0]        bus_size,
  input logic [WORD_W-1:0] rx_word,
  input logic [WORD_W-1:0] rd_word,
  input logic [WORD_W-1:0] tx_word,
  input logic              perr_n
);
  logic mbox_gen;
  logic any_lane_fail;
  logic lane0_ok;

  always_comb begin
    mbox_gen      = !is_write && gen_en && (bus_size == 2'b11);
    lane0_ok      = ((^rx_word[LANE_W-1:0]) == odd_sel);
    any_lane_fail = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if ((^rx_word[l*LANE_W +: LANE_W]) != odd_sel) any_lane_fail = 1'b1;
    end

    // R7
    mbox_gen_flag_chk: assert (!mbox_gen || perr_n)
      else $error("mailbox generation did not hold the flag high");
    // R3
    long_fail_flag_chk: assert (!(bus_size == 2'b00 && any_lane_fail) || !perr_n)
      else $error("long-word fault not flagged");
    // R3
    long_pass_flag_chk: assert (!(bus_size == 2'b00 && !any_lane_fail) || perr_n)
      else $error("long-word flag raised with all lanes clean");
    // R4
    byte_mask_chk: assert (!(bus_size == 2'b01 && lane0_ok) || perr_n)
      else $error("byte mode flagged an unchecked lane");
    // R6
    passthrough_chk: assert (!(is_write || !gen_en) || tx_word == rd_word)
      else $error("read word altered without generation");
    for (int l = 0; l < LANES; l++) begin
      // R5
      gen_lane_parity_chk: assert (!(!is_write && gen_en)
                                   || (^tx_word[l*LANE_W +: LANE_W]) == odd_sel)
        else $error("generated lane %0d has wrong parity", l);
      // R5
      data_bits_kept_chk: assert (tx_word[l*LANE_W +: LANE_W-1]
                                  == rd_word[l*LANE_W +: LANE_W-1])
        else $error("lane %0d data bits altered", l);
    end
  end
endmodule

bind lane_parity_unit lane_parity_unit_chk u_lane_parity_unit_chk (
  .odd_sel  (odd_sel),
  .gen_en   (gen_en),
  .is_write (is_write),
  .bus_size (bus_size),
  .rx_word  (rx_word),
  .rd_word  (rd_word),
  .tx_word  (tx_word),
  .perr_n   (perr_n)
);

// File: tb/lane_parity_unit_bench.sv
module lane_parity_unit_bench;
  logic        clk;
  logic        odd_sel;
  logic        gen_en;
  logic        is_write;
  logic [1:0]  bus_size;
  logic [35:0] rx_word;
  logic [35:0] rd_word;
  logic [35:0] tx_word;
  logic        perr_n;

  int n_chk  = 0;
  int n_fail = 0;

  lane_parity_unit u_lane_parity_unit (
    .odd_sel  (odd_sel),
    .gen_en   (gen_en),
    .is_write (is_write),
    .bus_size (bus_size),
    .rx_word  (rx_word),
    .rd_word  (rd_word),
    .tx_word  (tx_word),
    .perr_n   (perr_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Correct 9-bit lane for a data byte under the given sense.
  function automatic logic [8:0] good_lane(input logic [7:0] b, input logic odd);
    logic [3:0] ones;
    ones = 4'($countones(b));
    return {(odd ? (ones[0] == 1'b0) : (ones[0] == 1'b1)), b};
  endfunction

  function automatic logic [35:0] good_word(input logic [31:0] d, input logic odd);
    logic [35:0] w;
    for (int l = 0; l < 4; l++) w[l*9 +: 9] = good_lane(d[l*8 +: 8], odd);
    return w;
  endfunction

  task automatic check(input logic ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic odd, input logic gen, input logic wr,
                       input logic [1:0] sz, input logic [35:0] rx,
                       input logic [35:0] rd);
    @(posedge clk);
    odd_sel = odd; gen_en = gen; is_write = wr; bus_size = sz;
    rx_word = rx; rd_word = rd;
    @(negedge clk);
  endtask

  task automatic t_idle;
    drive(1'b0, 1'b0, 1'b1, 2'b00, 36'h0, 36'h0);
    check(perr_n === 1'b1, "R3", {35'b0, perr_n}, 36'h1);
    check(tx_word === 36'h0, "R6", tx_word, 36'h0);
  endtask

  task automatic t_sense;
    // Lane 0 holds a single one in its data and a zero parity bit: odd count.
    drive(1'b1, 1'b0, 1'b1, 2'b01, 36'h001, 36'h0);
    check(perr_n === 1'b1, "R2 odd", {35'b0, perr_n}, 36'h1);
    drive(1'b0, 1'b0, 1'b1, 2'b01, 36'h001, 36'h0);
    check(perr_n === 1'b0, "R2 even", {35'b0, perr_n}, 36'h0);
    drive(1'b0, 1'b0, 1'b1, 2'b01, 36'h101, 36'h0);
    check(perr_n === 1'b1, "R2 even ok", {35'b0, perr_n}, 36'h1);
  endtask

  task automatic t_lane_sweep;
    logic [35:0] w;
    w = good_word(32'hA5_3C_0F_96, 1'b1);
    drive(1'b1, 1'b0, 1'b1, 2'b00, w, 36'h0);
    check(perr_n === 1'b1, "R3 clean", {35'b0, perr_n}, 36'h1);
    for (int l = 0; l < 4; l++) begin
      drive(1'b1, 1'b0, 1'b1, 2'b00, w ^ (36'h100 << (l*9)), 36'h0);
      check(perr_n === 1'b0, "R1 parity bit", {35'b0, perr_n}, 36'h0);
      drive(1'b1, 1'b0, 1'b1, 2'b00, w ^ (36'h001 << (l*9)), 36'h0);
      check(perr_n === 1'b0, "R1 data bit", {35'b0, perr_n}, 36'h0);
    end
  endtask

  task automatic t_mask;
    logic [35:0] w;
    w = good_word(32'h12_34_56_78, 1'b0);
    for (int l = 1; l < 4; l++) begin
      drive(1'b0, 1'b0, 1'b1, 2'b01, w ^ (36'h100 << (l*9)), 36'h0);
      check(perr_n === 1'b1, "R4 byte masks upper", {35'b0, perr_n}, 36'h1);
    end
    drive(1'b0, 1'b0, 1'b1, 2'b01, w ^ 36'h100, 36'h0);
    check(perr_n === 1'b0, "R4 byte lane0", {35'b0, perr_n}, 36'h0);
    for (int l = 2; l < 4; l++) begin
      drive(1'b0, 1'b0, 1'b1, 2'b10, w ^ (36'h100 << (l*9)), 36'h0);
      check(perr_n === 1'b1, "R4 word masks upper", {35'b0, perr_n}, 36'h1);
    end
    drive(1'b0, 1'b0, 1'b1, 2'b10, w ^ (36'h100 << 9), 36'h0);
    check(perr_n === 1'b0, "R4 word lane1", {35'b0, perr_n}, 36'h0);
    drive(1'b0, 1'b0, 1'b1, 2'b11, w ^ (36'h100 << 27), 36'h0);
    check(perr_n === 1'b0, "R4 mailbox lane3", {35'b0, perr_n}, 36'h0);
  endtask

  task automatic t_generate;
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0102_0408, 32'hDEAD_BEEF};
    logic [35:0] raw;
    logic [35:0] exp;
    foreach (pats[i]) begin
      for (int o = 0; o < 2; o++) begin
        exp = good_word(pats[i], o[0]);
        raw = exp ^ 36'h8_0402_0100;   // flip every parity bit
        drive(o[0], 1'b1, 1'b0, 2'b00, 36'h0, raw);
        check(tx_word === exp, "R5 long", tx_word, exp);
        drive(o[0], 1'b1, 1'b0, 2'b11, 36'h0, raw);
        check(tx_word === exp, "R5 mailbox", tx_word, exp);
      end
    end
  endtask

  task automatic t_passthrough;
    logic [35:0] raw;
    raw = 36'h9_5A5A_A5A5;
    drive(1'b1, 1'b0, 1'b0, 2'b00, 36'h0, raw);
    check(tx_word === raw, "R6 gen off", tx_word, raw);
    drive(1'b1, 1'b1, 1'b1, 2'b11, 36'h0, raw);
    check(tx_word === raw, "R6 write", tx_word, raw);
  endtask

  task automatic t_mailbox_borrow;
    logic [35:0] bad;
    bad = 36'h8_0402_0100;   // all parity bits set, data zero: every lane fails even
    drive(1'b0, 1'b1, 1'b0, 2'b11, bad, 36'h0);
    check(perr_n === 1'b1, "R7 forced high", {35'b0, perr_n}, 36'h1);
    drive(1'b0, 1'b1, 1'b1, 2'b11, bad, 36'h0);
    check(perr_n === 1'b0, "R7 write still checks", {35'b0, perr_n}, 36'h0);
    drive(1'b0, 1'b0, 1'b0, 2'b11, bad, 36'h0);
    check(perr_n === 1'b0, "R7 no gen still checks", {35'b0, perr_n}, 36'h0);
    drive(1'b0, 1'b1, 1'b0, 2'b00, bad, 36'h0);
    check(perr_n === 1'b0, "R7 fifo read still checks", {35'b0, perr_n}, 36'h0);
  endtask

  task automatic t_comb;
    drive(1'b0, 1'b0, 1'b1, 2'b00, 36'h0, 36'h0);
    #2 rx_word = 36'h100;
    #1 check(perr_n === 1'b0, "R8 flag follows", {35'b0, perr_n}, 36'h0);
    rx_word = 36'h0;
    #1 check(perr_n === 1'b1, "R8 flag recovers", {35'b0, perr_n}, 36'h1);
    rd_word = 36'h0_0000_0001; gen_en = 1'b1; is_write = 1'b0;
    #1 check(tx_word === 36'h0_0000_0101, "R8 tx follows", tx_word, 36'h0_0000_0101);
  endtask

  initial begin
    odd_sel = 1'b0; gen_en = 1'b0; is_write = 1'b1; bus_size = 2'b00;
    rx_word = '0; rd_word = '0;
    repeat (2) @(posedge clk);
    t_idle;
    t_sense;
    t_lane_sweep;
    t_mask;
    t_generate;
    t_passthrough;
    t_mailbox_borrow;
    t_comb;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule